// File: doc/BRIEF.md
# Fault Classifier and Breaker Trip Logic

This block sits after a small neural-network scorer in a DC-grid protection relay. The scorer produces five signed fixed-point scores per decision: bus fault, protected-line fault, pole-to-pole fault, positive pole-to-ground fault and negative pole-to-ground fault. On each valid strobe the block turns every score into a binary flag. A score counts as set only when it lies strictly within a tolerance band around unity.

From the two location flags the block decides whether to open the breaker of the protected line alone, or every breaker adjacent to the bus. An input mask marks which breakers are adjacent to the bus. The three pole flags become a fault-type code. Any contradiction between the flags raises an inconsistency flag. Trip bits are sticky until reset, so a single-cycle decision cannot be lost. The type code and the inconsistency flag are refreshed on each valid strobe and held between strobes.

Top module: `fault_trip_classifier`

## Requirements
- R1: While reset is asserted and after its release, `tripVec` is all zeros, `faultType` is 0 (no fault) and `inconsistent` is 0.
- R2: A score (signed, FRAC_W=12 fraction bits by default, so 1.0 = 4096) counts as set only when strictly within 0.3 of 1.0. At the defaults that is 2867 < score < 5325. Scores of 2867, 5325 and negative values count as clear.
- R3: When `validIn` is high with the bus score set and the line score clear, every breaker marked in `adjMask` trips at the next clock edge.
- R4: When `validIn` is high with the line score set and the bus score clear, breaker index LOCAL_IDX (default 0) trips at the next clock edge, and no other breaker trips.
- R5: When both location scores are clear, no breaker trips and `faultType` becomes 0, whatever the three pole scores are.
- R6: When a location score is set, `faultType` reports the pole. Exactly one pole score set gives 1 for pole-to-pole (`ptpScore`), 2 for positive pole-to-ground (`posScore`) or 3 for negative pole-to-ground (`negScore`). Zero or several pole scores set gives 4 (undetermined).
- R7: `inconsistent` becomes 1 one cycle after a valid decision in either of two cases: both location scores are set, or a location score is set with a pole count other than one. Any other valid decision sets it to 0.
- R8: When both location scores are set, no breaker trips for that decision.
- R9: A trip bit, once set, stays set until reset.
- R10: Without `validIn`, `tripVec`, `faultType` and `inconsistent` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Scores and mask are valid this cycle |
| busScore | input | SCORE_W | Bus-fault score, signed fixed point |
| lineScore | input | SCORE_W | Protected-line fault score |
| ptpScore | input | SCORE_W | Pole-to-pole score |
| posScore | input | SCORE_W | Positive pole-to-ground score |
| negScore | input | SCORE_W | Negative pole-to-ground score |
| adjMask | input | NUM_BRK | Breakers adjacent to the protected bus |
| tripVec | output | NUM_BRK | Sticky trip command per breaker, 1 = trip |
| faultType | output | 3 | Fault-type code (0 none, 1 PTP, 2 positive, 3 negative, 4 undetermined) |
| inconsistent | output | 1 | Contradictory flags in the last decision |

## Verification
A wrong band edge shows as a trip or a code that appears or goes missing for scores that sit one step from 2867 or 5325. It is visible one cycle after the strobe. A broken decode of the location flags shows at once as the wrong breaker set in `tripVec`. Because trips are sticky, the error then stays visible until the next reset. A fault in the hold or pole-count logic shows as `faultType` or `inconsistent` changing without a strobe, or disagreeing with the pole scores, on the cycle after each decision.

// File: rtl/fault_trip_pkg.sv
package fault_trip_pkg;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_PTP     = 3'd1,
    FC_POS     = 3'd2,
    FC_NEG     = 3'd3,
    FC_UNKNOWN = 3'd4
  } faultCode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       load;
    logic       busTrip;
    logic       lineTrip;
    logic       incons;
    faultCode_e code;
  } strobe_t;

  localparam int NUM_SCORES = 5;
  localparam int IDX_BUS  = 0;
  localparam int IDX_LINE = 1;
  localparam int IDX_PTP  = 2;
  localparam int IDX_POS  = 3;
  localparam int IDX_NEG  = 4;

endpackage

// File: rtl/fault_band_cmp.sv
module fault_band_cmp #(
  parameter int SCORE_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int BAND_TENTHS = 3
) (
  input  logic signed [SCORE_W-1:0] score,
  output logic                      isSet
);
  localparam int ONE  = 1 << FRAC_W;
  localparam int BAND = (BAND_TENTHS * ONE + 5) / 10;
  localparam int LO   = ONE - BAND;
  localparam int HI   = ONE + BAND;

  logic signed [31:0] wide;

  always_comb begin
    wide  = 32'(score);
    isSet = (wide > LO) && (wide < HI);
  end
endmodule

// File: rtl/fault_trip_ctrl.sv
module fault_trip_ctrl
  import fault_trip_pkg::*;
(
  input  logic                  validIn,
  input  logic [NUM_SCORES-1:0] flags,
  output strobe_t               strobe
);
  logic       busF;
  logic       lineF;
  logic [2:0] poleF;
  logic       anyLoc;
  logic       bothLoc;
  logic       poleOne;

  always_comb begin
    busF    = flags[IDX_BUS];
    lineF   = flags[IDX_LINE];
    poleF   = {flags[IDX_NEG], flags[IDX_POS], flags[IDX_PTP]};
    anyLoc  = busF | lineF;
    bothLoc = busF & lineF;
    poleOne = (poleF == 3'b001) || (poleF == 3'b010) || (poleF == 3'b100);

    strobe.load     = validIn;
    strobe.busTrip  = validIn & busF & ~lineF;
    strobe.lineTrip = validIn & lineF & ~busF;
    strobe.incons   = bothLoc | (anyLoc & ~poleOne);

    if (!anyLoc)       strobe.code = FC_NONE;
    else if (!poleOne) strobe.code = FC_UNKNOWN;
    else if (poleF[0]) strobe.code = FC_PTP;
    else if (poleF[1]) strobe.code = FC_POS;
    else               strobe.code = FC_NEG;
  end
endmodule

// File: rtl/fault_trip_dp.sv
module fault_trip_dp
  import fault_trip_pkg::*;
#(
  parameter int NUM_BRK   = 4,
  parameter int LOCAL_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strobe,
  input  logic [NUM_BRK-1:0] adjMask,
  output logic [NUM_BRK-1:0] tripVec,
  output logic [2:0]         faultType,
  output logic               inconsistent
);
  logic [NUM_BRK-1:0] localBit;
  logic [NUM_BRK-1:0] tripSet;

  always_comb begin
    localBit = '0;
    localBit[LOCAL_IDX] = 1'b1;
    tripSet = (strobe.busTrip ? adjMask : '0) | (strobe.lineTrip ? localBit : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripVec      <= '0;
      faultType    <= FC_NONE;
      inconsistent <= 1'b0;
    end else if (strobe.load) begin
      tripVec      <= tripVec | tripSet;
      faultType    <= strobe.code;
      inconsistent <= strobe.incons;
    end
  end
endmodule

// File: rtl/fault_trip_classifier.sv
module fault_trip_classifier
  import fault_trip_pkg::*;
#(
  parameter int NUM_BRK     = 4,
  parameter int LOCAL_IDX   = 0,
  parameter int SCORE_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int BAND_TENTHS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               validIn,
  input  logic [SCORE_W-1:0] busScore,
  input  logic [SCORE_W-1:0] lineScore,
  input  logic [SCORE_W-1:0] ptpScore,
  input  logic [SCORE_W-1:0] posScore,
  input  logic [SCORE_W-1:0] negScore,
  input  logic [NUM_BRK-1:0] adjMask,
  output logic [NUM_BRK-1:0] tripVec,
  output logic [2:0]         faultType,
  output logic               inconsistent
);
  logic [SCORE_W-1:0]    scores [NUM_SCORES];
  logic [NUM_SCORES-1:0] flags;
  strobe_t               strobe;

  assign scores[IDX_BUS]  = busScore;
  assign scores[IDX_LINE] = lineScore;
  assign scores[IDX_PTP]  = ptpScore;
  assign scores[IDX_POS]  = posScore;
  assign scores[IDX_NEG]  = negScore;

  for (genvar g = 0; g < NUM_SCORES; g++) begin : g_band
    fault_band_cmp #(
      .SCORE_W(SCORE_W), .FRAC_W(FRAC_W), .BAND_TENTHS(BAND_TENTHS)
    ) u_cmp (
      .score(scores[g]),
      .isSet(flags[g])
    );
  end

  fault_trip_ctrl u_ctrl (
    .validIn(validIn),
    .flags(flags),
    .strobe(strobe)
  );

  fault_trip_dp #(.NUM_BRK(NUM_BRK), .LOCAL_IDX(LOCAL_IDX)) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .adjMask(adjMask),
    .tripVec(tripVec),
    .faultType(faultType),
    .inconsistent(inconsistent)
  );
endmodule

// File: rtl/fault_trip_classifier_chk.sv
module fault_trip_classifier_chk #(
  parameter int NUM_BRK     = 4,
  parameter int LOCAL_IDX   = 0,
  parameter int SCORE_W     = 16,
  parameter int FRAC_W      = 12,
  parameter int BAND_TENTHS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               validIn,
  input logic [SCORE_W-1:0] busScore,
  input logic [SCORE_W-1:0] lineScore,
  input logic [NUM_BRK-1:0] adjMask,
  input logic [NUM_BRK-1:0] tripVec,
  input logic [2:0]         faultType,
  input logic               inconsistent
);
  localparam int ONE  = 1 << FRAC_W;
  localparam int BAND = (BAND_TENTHS * ONE + 5) / 10;

  function automatic logic near(input logic [SCORE_W-1:0] s);
    int v;
    v = int'($signed(s));
    return (v > ONE - BAND) && (v < ONE + BAND);
  endfunction

  logic busSet;
  logic lineSet;
  assign busSet  = near(busScore);
  assign lineSet = near(lineScore);

  // R9: trip bits never fall outside reset
  a_r9_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tripVec & $past(tripVec)) == $past(tripVec)));

  // R10: outputs hold without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !validIn |=> ($stable(tripVec) && $stable(faultType) && $stable(inconsistent)));

  // R3: bus decision opens all adjacent breakers
  a_r3_bus_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (validIn && busSet && !lineSet) |=> ((tripVec & $past(adjMask)) == $past(adjMask)));

  // R4: line decision opens the local breaker
  a_r4_line_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (validIn && lineSet && !busSet) |=> tripVec[LOCAL_IDX]);

  // R8: conflicting location flags trip nothing and raise the flag
  a_r8_both_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (validIn && lineSet && busSet) |=> (tripVec == $past(tripVec) && inconsistent));

  // R6/R7: undetermined pole always comes with the inconsistency flag
  a_r6_unknown_incons: assert property (@(posedge clk) disable iff (!rst_n)
    (faultType == 3'd4) |-> inconsistent);
endmodule

bind fault_trip_classifier fault_trip_classifier_chk #(
  .NUM_BRK(NUM_BRK), .LOCAL_IDX(LOCAL_IDX), .SCORE_W(SCORE_W),
  .FRAC_W(FRAC_W), .BAND_TENTHS(BAND_TENTHS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .validIn(validIn),
  .busScore(busScore), .lineScore(lineScore), .adjMask(adjMask),
  .tripVec(tripVec), .faultType(faultType), .inconsistent(inconsistent)
);

// File: tb/sim_fault_trip_classifier.sv
`timescale 1ns/1ps
module sim_fault_trip_classifier;
  localparam int NB = 4;
  localparam int SW = 16;
  localparam int LO = 2867;
  localparam int HI = 5325;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic validIn = 1'b0;
  logic [SW-1:0] busScore = '0, lineScore = '0, ptpScore = '0, posScore = '0, negScore = '0;
  logic [NB-1:0] adjMask = '0;
  logic [NB-1:0] tripVec;
  logic [2:0]    faultType;
  logic          inconsistent;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] expTrip = '0;
  logic [2:0]    expCode = '0;
  logic          expInc = 1'b0;

  always #2 clk = ~clk;

  fault_trip_classifier u0 (
    .clk(clk), .rst_n(rst_n), .validIn(validIn),
    .busScore(busScore), .lineScore(lineScore), .ptpScore(ptpScore),
    .posScore(posScore), .negScore(negScore), .adjMask(adjMask),
    .tripVec(tripVec), .faultType(faultType), .inconsistent(inconsistent)
  );

  function automatic logic setOf(input logic [SW-1:0] s);
    int v;
    v = int'($signed(s));
    return (v > LO) && (v < HI);
  endfunction

  function automatic logic [SW-1:0] pick(input logic wantSet);
    if (wantSet) return SW'($urandom_range(LO + 1, HI - 1));
    case ($urandom_range(0, 2))
      0:       return SW'($urandom_range(0, LO));
      1:       return SW'($urandom_range(HI, 16000));
      default: return SW'(-$signed(17'($urandom_range(1, 8000))));
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model();
    logic b, l;
    logic [2:0] p;
    int n;
    b = setOf(busScore);
    l = setOf(lineScore);
    p = {setOf(negScore), setOf(posScore), setOf(ptpScore)};
    n = $countones(p);
    if (b && !l) expTrip = expTrip | adjMask;
    if (l && !b) expTrip[0] = 1'b1;
    if (!(b || l))  expCode = 3'd0;
    else if (n != 1) expCode = 3'd4;
    else if (p[0])  expCode = 3'd1;
    else if (p[1])  expCode = 3'd2;
    else            expCode = 3'd3;
    expInc = (b && l) || ((b || l) && n != 1);
  endtask

  function automatic string tripTag();
    logic b, l;
    b = setOf(busScore);
    l = setOf(lineScore);
    if (b && l) return "R8";
    if (b) return "R3";
    if (l) return "R4";
    return "R5";
  endfunction

  task automatic decide(input logic [SW-1:0] b, input logic [SW-1:0] l,
                        input logic [SW-1:0] pt, input logic [SW-1:0] ps,
                        input logic [SW-1:0] ng, input logic [NB-1:0] m,
                        input string tag);
    string tt;
    @(negedge clk);
    busScore = b; lineScore = l; ptpScore = pt; posScore = ps; negScore = ng;
    adjMask = m; validIn = 1'b1;
    model();
    tt = tripTag();
    @(negedge clk);
    validIn = 1'b0;
    check({tag, " ", tt, " trip"}, int'(tripVec), int'(expTrip));
    check({tag, " R6 code"}, int'(faultType), int'(expCode));
    check({tag, " R7 incons"}, int'(inconsistent), int'(expInc));
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    expTrip = '0; expCode = '0; expInc = 1'b0;
    @(negedge clk);
    check("R1 reset trip", int'(tripVec), 0);
    check("R1 reset code", int'(faultType), 0);
    check("R1 reset incons", int'(inconsistent), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release trip", int'(tripVec), 0);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [SW-1:0] ON  = 16'd4096;
  localparam logic [SW-1:0] OFF = 16'd0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    doReset();

    // R2 band edges on the bus score
    decide(16'd2867, OFF, ON, OFF, OFF, 4'b0110, "R2 lo edge clear");
    decide(16'd5325, OFF, ON, OFF, OFF, 4'b0110, "R2 hi edge clear");
    decide(16'hF000, OFF, ON, OFF, OFF, 4'b0110, "R2 negative clear");
    decide(16'd2868, OFF, ON, OFF, OFF, 4'b0110, "R2 lo edge set");
    doReset();
    decide(16'd5324, OFF, OFF, ON, OFF, 4'b1001, "R2 hi edge set");
    doReset();

    // R4 line only, R6 each pole code
    decide(OFF, ON, OFF, OFF, ON, 4'b1111, "R4 line neg");
    decide(OFF, ON, ON, ON, OFF, 4'b1111, "R6 two poles");
    decide(OFF, ON, OFF, OFF, OFF, 4'b1111, "R6 no pole");
    // R5 pole flags ignored without location
    decide(OFF, OFF, ON, ON, ON, 4'b1111, "R5 poles only");
    doReset();
    // R8 both location flags
    decide(ON, ON, ON, OFF, OFF, 4'b1111, "R8 both");
    decide(OFF, OFF, OFF, OFF, OFF, 4'b1111, "R7 clear");

    // R10 hold without strobe, inputs wiggling
    decide(ON, OFF, OFF, OFF, ON, 4'b0101, "R3 bus");
    @(negedge clk);
    busScore = ON; lineScore = ON; adjMask = 4'b1111; posScore = ON;
    repeat (3) @(negedge clk);
    check("R10 hold trip", int'(tripVec), int'(expTrip));
    check("R10 hold code", int'(faultType), int'(expCode));
    check("R10 hold incons", int'(inconsistent), int'(expInc));

    // random decisions; R9 sticky trip checked through the model
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) doReset();
      decide(pick($urandom_range(0, 2) == 0), pick($urandom_range(0, 2) == 0),
             pick($urandom_range(0, 1) == 0), pick($urandom_range(0, 1) == 0),
             pick($urandom_range(0, 1) == 0), NB'($urandom_range(0, 15)),
             "R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule